// File: doc/BRIEF.md
# CAN Driver Protection Controller

This block sits in one channel of a CAN transceiver, between the drive request produced by the repeater logic and the enable of the physical bus driver. The drive request is active low: a low level asks the driver to put a dominant bit on the bus. The block lets the request through only while no protection condition holds. It keeps a dominant time-out timer so that a request stuck low cannot block the bus. It also watches a thermal shutdown flag, a short-to-battery comparator that must hold for a debounce window, and an external disable.

Each protection turns off only this channel's driver. The block does not touch receive data, so reception on the channel keeps running. Two flags report the time-out and the latched short. The time-out length and the debounce length are parameters counted in clock cycles. The thermal and short inputs are asynchronous, so each passes through a two-stage synchronizer.

Top module: `can_drv_guard`

## Requirements
- R1: While `rst_ni` is low, `drv_en_o`, `tmo_o` and `stb_o` are 0, whatever the other inputs do.
- R2: With no fault, time-out or disable present, `drv_en_o` is 1 in the same cycle that `tx_req_ni` is 0 (dominant) and 0 while it is 1 (recessive). It is never 1 while `tx_req_ni` is 1.
- R3: `tmo_o` rises after the clock edge at which `tx_req_ni` has been sampled low on `TMO_CYCLES` consecutive edges, counted from its falling edge. While `tmo_o` is 1, `drv_en_o` is 0.
- R4: While `tx_req_ni` stays low, `tmo_o` stays 1; time passing does not clear it. It clears on the first edge that samples `tx_req_ni` high after a low, and the next dominant request reaches the driver again.
- R5: While `dis_i` is 1, `drv_en_o` is 0. The time-out timer and the short detector keep working while the driver is disabled.
- R6: `ovt_i` at 1 forces `drv_en_o` to 0 from the second clock edge after it is sampled. It is not latched and does not change `tmo_o` or `stb_o`.
- R7: `stb_o` sets once the synchronized short comparator has been high on `DEB_CYCLES` consecutive edges. While `stb_o` is 1, `drv_en_o` is 0. A pulse shorter than that window leaves `stb_o` at 0.
- R8: A latched `stb_o` clears once the synchronized comparator has been low on `DEB_CYCLES` consecutive edges.
- R9: If the request returns high before the time-out is reached, the count is discarded. A later low period counts again from one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_req_ni | input | 1 | Drive request, 0 = dominant |
| ovt_i | input | 1 | Thermal shutdown flag, asynchronous |
| stb_raw_i | input | 1 | Raw short-to-battery comparator, asynchronous |
| dis_i | input | 1 | Driver disable, 1 = off |
| drv_en_o | output | 1 | Final driver enable |
| tmo_o | output | 1 | Dominant time-out flag |
| stb_o | output | 1 | Debounced short-to-battery flag |

## Verification
The assertions assume that `tx_req_ni` and `dis_i` are synchronous to `clk_i`. The stimulus therefore changes every input half a cycle away from the rising edge. The short and thermal checks relate the outputs to the raw inputs a fixed number of edges earlier, so they assume each input is seen by the first synchronizer stage at the edge that follows its change. Holding inputs stable across each edge makes that true. The bench also keeps every fault-free low period shorter than the time-out, except where the time-out itself is the subject, so that time-out effects never mix with the effects under test.

// File: rtl/can_guard_pkg.sv
package can_guard_pkg;
  localparam int SYNC_STAGES = 2;

  typedef struct packed {
    logic thermal;
    logic batt;
  } cg_flt_t;
endpackage

// File: rtl/cg_sync.sv
module cg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= {st_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/cg_dom_timer.sv
module cg_dom_timer #(
  parameter int TMO_CYCLES = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_ni,
  output logic tmo_o
);
  localparam int CW = $clog2(TMO_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TMO_CYCLES);

  logic          req_q, tmo_q;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          low, fall, rise;

  assign low  = ~req_ni;
  assign fall = req_q & low;
  assign rise = ~req_q & ~low;

  always_comb begin
    if (!low)                cnt_nxt = '0;
    else if (fall)           cnt_nxt = CW'(1);
    else if (cnt_q < LIMIT)  cnt_nxt = cnt_q + CW'(1);
    else                     cnt_nxt = cnt_q;
  end

  // flag clears only on the rising edge, never by elapsed time
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b1;
      cnt_q <= '0;
      tmo_q <= 1'b0;
    end else begin
      req_q <= req_ni;
      cnt_q <= cnt_nxt;
      if (rise)                            tmo_q <= 1'b0;
      else if (low && (cnt_nxt == LIMIT))  tmo_q <= 1'b1;
    end
  end

  assign tmo_o = tmo_q;
endmodule

// File: rtl/cg_debounce.sv
module cg_debounce #(
  parameter int DEB_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic out_o
);
  localparam int CW = $clog2(DEB_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      st_q  <= 1'b0;
    end else if (in_i != st_q) begin
      if (cnt_q == LAST) begin
        st_q  <= in_i;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign out_o = st_q;
endmodule

// File: rtl/can_drv_guard.sv
module can_drv_guard
  import can_guard_pkg::*;
#(
  parameter int TMO_CYCLES = 32768,
  parameter int DEB_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_req_ni,
  input  logic ovt_i,
  input  logic stb_raw_i,
  input  logic dis_i,
  output logic drv_en_o,
  output logic tmo_o,
  output logic stb_o
);
  cg_flt_t flt_raw, flt_s;
  logic    tmo, stb, rdy_q;

  assign flt_raw = '{thermal: ovt_i, batt: stb_raw_i};

  cg_sync #(.W($bits(cg_flt_t)), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (flt_raw),
    .q_o    (flt_s)
  );

  cg_dom_timer #(.TMO_CYCLES(TMO_CYCLES)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_ni (tx_req_ni),
    .tmo_o  (tmo)
  );

  cg_debounce #(.DEB_CYCLES(DEB_CYCLES)) i_deb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   (flt_s.batt),
    .out_o  (stb)
  );

  // keeps the driver recessive until the first edge after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdy_q <= 1'b0;
    else         rdy_q <= 1'b1;
  end

  assign drv_en_o = rdy_q & ~tx_req_ni & ~tmo & ~flt_s.thermal & ~stb & ~dis_i;
  assign tmo_o    = tmo;
  assign stb_o    = stb;
endmodule

// File: rtl/cg_guard_chk.sv
module cg_guard_chk #(
  parameter int TMO_CYCLES = 32768
) (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_req_ni,
  input logic ovt_i,
  input logic stb_raw_i,
  input logic dis_i,
  input logic drv_en_o,
  input logic tmo_o,
  input logic stb_o
);
  int low_run;
  int up_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_run <= 0;
      up_cnt  <= 0;
    end else begin
      if (tx_req_ni)                low_run <= 0;
      else if (low_run < TMO_CYCLES) low_run <= low_run + 1;
      if (up_cnt < 3) up_cnt <= up_cnt + 1;
    end
  end

  a_r2_drv_needs_dom: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_en_o |-> !tx_req_ni);
  a_r5_dis_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_i |-> !drv_en_o);
  a_r3_tmo_after_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tmo_o) |-> (low_run == TMO_CYCLES));
  a_r3_tmo_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_o |-> !drv_en_o);
  a_r4_tmo_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_o && !tx_req_ni) |=> tmo_o);
  a_r4_tmo_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_req_ni) |=> !tmo_o);
  a_r6_ovt_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((up_cnt >= 2) && $past(ovt_i, 2)) |-> !drv_en_o);
  a_r7_stb_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stb_o) |-> $past(stb_raw_i, 3));
  a_r7_stb_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |-> !drv_en_o);
  a_r8_stb_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stb_o) |-> !$past(stb_raw_i, 3));
endmodule

bind can_drv_guard cg_guard_chk #(.TMO_CYCLES(TMO_CYCLES)) i_guard_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tx_req_ni (tx_req_ni),
  .ovt_i     (ovt_i),
  .stb_raw_i (stb_raw_i),
  .dis_i     (dis_i),
  .drv_en_o  (drv_en_o),
  .tmo_o     (tmo_o),
  .stb_o     (stb_o)
);

// File: tb/test_can_drv_guard.sv
module test_can_drv_guard;
  localparam int TMO = 20;
  localparam int DEB = 5;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tx_req_ni = 1'b0;
  logic ovt_i = 1'b0;
  logic stb_raw_i = 1'b0;
  logic dis_i = 1'b0;
  logic drv_en_o, tmo_o, stb_o;

  always #10 clk_i = ~clk_i;

  can_drv_guard #(.TMO_CYCLES(TMO), .DEB_CYCLES(DEB)) i_can_drv_guard (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tx_req_ni (tx_req_ni),
    .ovt_i     (ovt_i),
    .stb_raw_i (stb_raw_i),
    .dis_i     (dis_i),
    .drv_en_o  (drv_en_o),
    .tmo_o     (tmo_o),
    .stb_o     (stb_o)
  );

  typedef struct {
    logic  drv;
    logic  tmo;
    logic  stb;
    string tag;
  } exp_t;

  exp_t sb[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  // reference state, advanced once per clock edge
  logic m_prev = 1'b1, m_tmo = 1'b0, m_o1 = 1'b0, m_o2 = 1'b0;
  logic m_s1 = 1'b0, m_s2 = 1'b0, m_sq = 1'b0;
  int   m_cnt = 0, m_dcnt = 0;

  task automatic chk(string tag, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic cyc(logic req, logic ovt, logic stb, logic dis, string tag);
    exp_t e;
    @(negedge clk_i);
    tx_req_ni = req; ovt_i = ovt; stb_raw_i = stb; dis_i = dis;
    if (m_s2 != m_sq) begin
      if (m_dcnt == DEB - 1) begin m_sq = m_s2; m_dcnt = 0; end
      else m_dcnt++;
    end else m_dcnt = 0;
    m_s2 = m_s1; m_s1 = stb;
    m_o2 = m_o1; m_o1 = ovt;
    if (!req) begin
      if (m_prev) m_cnt = 1;
      else if (m_cnt < TMO) m_cnt++;
      if (m_cnt == TMO) m_tmo = 1'b1;
    end else begin
      if (!m_prev) m_tmo = 1'b0;
      m_cnt = 0;
    end
    m_prev = req;
    e.drv = !req && !m_tmo && !m_o2 && !m_sq && !dis;
    e.tmo = m_tmo;
    e.stb = m_sq;
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic run(int n, logic req, logic ovt, logic stb, logic dis, string tag);
    for (int i = 0; i < n; i++) cyc(req, ovt, stb, dis, tag);
  endtask

  // monitor: compares after each edge once outputs have settled
  initial begin
    forever begin
      @(posedge clk_i);
      #5;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, "drv_en_o", drv_en_o, e.drv);
        chk(e.tag, "tmo_o", tmo_o, e.tmo);
        chk(e.tag, "stb_o", stb_o, e.stb);
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: dominant request and faults held during reset
    ovt_i = 1'b0; stb_raw_i = 1'b1; tx_req_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R1", "drv_en_o", drv_en_o, 1'b0);
    chk("R1", "tmo_o", tmo_o, 1'b0);
    chk("R1", "stb_o", stb_o, 1'b0);
    stb_raw_i = 1'b0; tx_req_ni = 1'b1;
    @(negedge clk_i);
    rst_ni = 1'b1;
    run(2, 1, 0, 0, 0, "R1");
    // R2: request passes through
    run(3, 0, 0, 0, 0, "R2");
    run(2, 1, 0, 0, 0, "R2");
    cyc(0, 0, 0, 0, "R2");
    cyc(1, 0, 0, 0, "R2");
    // R9: short lows never time out
    run(15, 0, 0, 0, 0, "R9");
    cyc(1, 0, 0, 0, "R9");
    run(15, 0, 0, 0, 0, "R9");
    run(2, 1, 0, 0, 0, "R9");
    // R3 / R4: time-out, hold, clear on rise
    run(TMO + 5, 0, 0, 0, 0, "R3");
    run(6, 0, 0, 0, 0, "R4");
    run(2, 1, 0, 0, 0, "R4");
    run(3, 0, 0, 0, 0, "R4");
    cyc(1, 0, 0, 0, "R4");
    // R5: disable blocks driver, timer keeps counting
    run(4, 0, 0, 0, 1, "R5");
    run(2, 0, 0, 0, 0, "R5");
    cyc(1, 0, 0, 0, "R5");
    run(TMO + 2, 0, 0, 0, 1, "R5");
    run(2, 0, 0, 0, 0, "R5");
    run(2, 1, 0, 0, 0, "R5");
    // R6: thermal, two-stage latency, not latched
    run(4, 0, 1, 0, 0, "R6");
    run(4, 0, 0, 0, 0, "R6");
    cyc(1, 0, 0, 0, "R6");
    // R7: glitch ignored, then a real short latches
    run(DEB - 2, 0, 0, 1, 0, "R7");
    run(4, 0, 0, 0, 0, "R7");
    cyc(1, 0, 0, 0, "R7");
    run(DEB + 4, 1, 0, 1, 0, "R7");
    run(3, 0, 0, 1, 0, "R7");
    // R8: release after a low window
    run(DEB + 4, 0, 0, 0, 0, "R8");
    run(2, 1, 0, 0, 0, "R8");
    // R8: a short low pulse does not release the latch
    run(DEB + 4, 1, 0, 1, 0, "R8");
    run(DEB - 2, 1, 0, 0, 0, "R8");
    run(3, 0, 0, 1, 0, "R8");
    run(DEB + 4, 1, 0, 0, 0, "R8");
    repeat (3) @(negedge clk_i);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule